// File: doc/BRIEF.md
# Polling Bus Arbiter

This block shares one bus among a parameterised number of masters without any per-master grant line. A central counter broadcasts a device number to every master. While at least one master is asking for the bus and nobody holds it, the counter moves to the next number on each clock. A master that is asking and sees its own number on the count takes the bus by raising its busy output. The shared busy line then stops the counter.

The owner keeps the bus for as long as it holds its request. When it lets the request go, the bus is freed and the count continues from the number after the released owner. Priority therefore comes from the order in which the count visits the device numbers. A requester may wait up to a full lap of the count before it is served, which is the latency cost of this scheme.

Each master has its own claim unit inside the block. The shared request and busy lines are brought out so the rest of the system can observe the state of the bus.

Top module: `poll_bus_arbiter`

## Requirements
- R1: At most one bit of `dev_busy` is high in any cycle.
- R2: `bus_req` is high in the same cycle exactly when at least one bit of `dev_req` is high.
- R3: `bus_busy` is high exactly when some bit of `dev_busy` is high.
- R4: After a clock edge with `rst_n` low, `poll_cnt` is 0 and every `dev_busy` bit is low.
- R5: After an edge at which `bus_req` is high and `bus_busy` is low, `poll_cnt` equals its previous value plus one, and it goes from N_DEV-1 to 0.
- R6: After an edge at which `bus_busy` is high or `bus_req` is low, `poll_cnt` keeps its previous value.
- R7: If `dev_req[i]` is high, `poll_cnt` equals i and `bus_busy` is low at an edge, then `dev_busy[i]` is high after that edge. Otherwise a device that does not own the bus stays idle.
- R8: While the bus is owned, a requesting device whose number is shown on `poll_cnt` does not take the bus.
- R9: An owner keeps `dev_busy[i]` high while `dev_req[i]` stays high. It drops `dev_busy[i]` after the first edge at which `dev_req[i]` is low.
- R10: When several devices request while the bus is free, the first requesting number reached by the count from its current value takes the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dev_req | input | N_DEV | Per-master request, bit i belongs to master i |
| dev_busy | output | N_DEV | Per-master busy drive, high while master i owns the bus |
| bus_req | output | 1 | Shared request line, the OR of all requests |
| bus_busy | output | 1 | Shared busy line, the OR of all busy drives |
| poll_cnt | output | $clog2(N_DEV) | Broadcast polling count |

## Verification
The bench builds the arbiter with five masters rather than the default eight. Five is not a power of two, so the count has to wrap from 4 back to 0 while the 3-bit register could still represent 5, 6 and 7; a missing wrap shows up within one lap. With five masters, overlapping random requests often leave two or more masters waiting on different numbers. This exercises the count-order priority, and the frozen count often lands on a waiting master's number while another master owns the bus.

// File: rtl/poll_arb_pkg.sv
// Shared helpers for the polling bus arbiter.
// Assumes device numbers run from 0 to n-1 with n at least 1.
package poll_arb_pkg;

    // Next device number in polling order, wrapping after the last one.
    function automatic int poll_next(input int cur, input int n);
        if (cur >= n - 1)
            return 0;
        return cur + 1;
    endfunction

endpackage

// File: rtl/poll_counter.sv
// Polling count register: it steps through device numbers when told
// to advance and holds otherwise.
// Assumes advance is already qualified by the shared request and busy lines.
module poll_counter #(
    parameter int N_DEV = 8,
    parameter int CW    = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          advance,
    output logic [CW-1:0] cnt
);
    import poll_arb_pkg::*;

    // Step to the next device number, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (advance)
            cnt <= CW'(poll_next(int'(cnt), N_DEV));
    end

endmodule

// File: rtl/claim_unit.sv
// Per-master claim logic. It takes the bus when its own number is polled
// while it requests and the bus is free. It keeps the bus until its
// request drops.
// Assumes bus_busy is the registered OR of all owners.
module claim_unit #(
    parameter int CW     = 3,
    parameter int DEV_ID = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic [CW-1:0] poll_cnt,
    input  logic          bus_busy,
    output logic          owns
);
    logic polled;

    // Own number currently on the broadcast count.
    assign polled = (poll_cnt == CW'(DEV_ID));

    // Claim on match with a free bus, keep while requesting.
    always_ff @(posedge clk) begin
        if (!rst_n)
            owns <= 1'b0;
        else if (owns)
            owns <= req;
        else
            owns <= req && polled && !bus_busy;
    end

endmodule

// File: rtl/poll_bus_arbiter.sv
// Polling bus arbiter top: a central poll counter plus one claim unit per
// master, joined by shared request and busy lines.
// Assumes requests are synchronous to clk.
module poll_bus_arbiter #(
    parameter int N_DEV = 8,
    parameter int CW    = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_DEV-1:0] dev_req,
    output logic [N_DEV-1:0] dev_busy,
    output logic             bus_req,
    output logic             bus_busy,
    output logic [CW-1:0]    poll_cnt
);
    logic advance;

    // Shared lines are wired-OR of the per-master drives.
    assign bus_req  = |dev_req;
    assign bus_busy = |dev_busy;

    // Count moves only while someone waits and nobody owns the bus.
    assign advance  = bus_req && !bus_busy;

    poll_counter #(.N_DEV(N_DEV), .CW(CW)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (advance),
        .cnt     (poll_cnt)
    );

    for (genvar g = 0; g < N_DEV; g++) begin : g_dev
        claim_unit #(.CW(CW), .DEV_ID(g)) u_claim (
            .clk      (clk),
            .rst_n    (rst_n),
            .req      (dev_req[g]),
            .poll_cnt (poll_cnt),
            .bus_busy (bus_busy),
            .owns     (dev_busy[g])
        );
    end

endmodule

// File: rtl/poll_arb_checker.sv
// Property checker for the polling bus arbiter, attached by bind.
// Assumes synchronous active-low reset.
module poll_arb_checker #(
    parameter int N_DEV = 8,
    parameter int CW    = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_DEV-1:0] dev_req,
    input logic [N_DEV-1:0] dev_busy,
    input logic             bus_req,
    input logic             bus_busy,
    input logic [CW-1:0]    poll_cnt
);
    assert_single_owner_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dev_busy));

    assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_busy) |=>
            (poll_cnt == (($past(poll_cnt) == CW'(N_DEV - 1)) ? '0 : $past(poll_cnt) + 1'b1)));

    assert_count_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_busy || !bus_req) |=> $stable(poll_cnt));

    for (genvar g = 0; g < N_DEV; g++) begin : g_chk
        assert_claim_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(dev_busy[g]) |->
                ($past(dev_req[g]) && ($past(poll_cnt) == CW'(g)) && !$past(bus_busy)));

        assert_no_steal_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_busy && !dev_busy[g]) |=> !dev_busy[g]);

        assert_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (dev_busy[g] && dev_req[g]) |=> dev_busy[g]);

        assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (dev_busy[g] && !dev_req[g]) |=> !dev_busy[g]);
    end

endmodule

bind poll_bus_arbiter poll_arb_checker #(.N_DEV(N_DEV), .CW(CW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .dev_req  (dev_req),
    .dev_busy (dev_busy),
    .bus_req  (bus_req),
    .bus_busy (bus_busy),
    .poll_cnt (poll_cnt)
);

// File: tb/poll_bus_arbiter_test.sv
`timescale 1ns/1ps
module poll_bus_arbiter_test;
    localparam int N  = 5;
    localparam int CW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  dev_req = '0;
    logic [N-1:0]  dev_busy;
    logic          bus_req;
    logic          bus_busy;
    logic [CW-1:0] poll_cnt;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    int            m_cnt = 0;
    logic [N-1:0]  m_own = '0;

    poll_bus_arbiter #(.N_DEV(N)) uut (
        .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .dev_busy(dev_busy),
        .bus_req(bus_req), .bus_busy(bus_busy), .poll_cnt(poll_cnt)
    );

    always #10 clk = ~clk;

    function automatic int wrap_inc(input int c);
        return (c == N - 1) ? 0 : c + 1;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Apply one request pattern for one clock and compare against the model.
    task automatic cycle(input logic [N-1:0] req);
        logic [N-1:0] own_n;
        int  cnt_n;
        bit  bb;
        bit  adv;
        bit  blocked;
        dev_req = req;
        #1;
        check("R2 bus_req", int'(bus_req), int'(|req));
        bb = (m_own != '0);
        blocked = bb && !m_own[m_cnt] && req[m_cnt];
        own_n = m_own;
        for (int i = 0; i < N; i++) begin
            if (m_own[i]) own_n[i] = req[i];
            else          own_n[i] = req[i] && (m_cnt == i) && !bb;
        end
        adv = (req != '0) && !bb;
        cnt_n = adv ? wrap_inc(m_cnt) : m_cnt;
        @(posedge clk);
        @(negedge clk);
        check(adv ? "R5 count step" : "R6 count hold", int'(poll_cnt), cnt_n);
        if (own_n != m_own && (own_n & ~m_own) != '0)
            check("R7 claim", int'(dev_busy), int'(own_n));
        else if (blocked)
            check("R8 no claim while owned", int'(dev_busy), int'(own_n));
        else
            check("R9 owner keep/release", int'(dev_busy), int'(own_n));
        check("R1 one owner", $countones(dev_busy) <= 1 ? 1 : 0, 1);
        check("R3 bus_busy", int'(bus_busy), int'(own_n != '0));
        m_own = own_n;
        m_cnt = cnt_n;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    initial begin
        logic [N-1:0] r;
        void'($urandom(32'd20240611));
        @(negedge clk);
        @(negedge clk);
        check("R4 reset count", int'(poll_cnt), 0);
        check("R4 reset busy", int'(dev_busy), 0);
        rst_n = 1'b1;
        // Idle: count holds at 0.
        for (int k = 0; k < 3; k++) cycle('0);
        // Single requester 3: walks 0..3, claims, count frozen at 4.
        for (int k = 0; k < 4; k++) cycle(5'b01000);
        check("R7 dev3 owns", int'(dev_busy), 8);
        // Device 4 requests while its number is frozen on the count.
        for (int k = 0; k < 3; k++) cycle(5'b11000);
        check("R8 dev4 waits", int'(dev_busy), 8);
        cycle(5'b10000);
        cycle(5'b10000);
        check("R7 dev4 owns", int'(dev_busy), 16);
        cycle(5'b00000);
        // Count now 0 after wrap; 1 and 3 request from count 2.
        cycle(5'b00000);
        cycle(5'b00100);
        cycle(5'b00100);
        cycle(5'b00000);
        check("R5 wrap count", int'(poll_cnt), m_cnt);
        // Priority: count at m_cnt, both 1 and 3 request.
        while (m_cnt != 2) cycle(5'b00001 << ((m_cnt + 2) % N) & 5'b00000);
        for (int k = 0; k < 2; k++) cycle(5'b01010);
        check("R10 dev3 before dev1", int'(dev_busy), 8);
        cycle(5'b00010);
        for (int k = 0; k < 4; k++) cycle(5'b00010);
        check("R10 dev1 served next", int'(dev_busy), 2);
        cycle('0);
        // Random traffic with sticky requests.
        r = '0;
        for (int k = 0; k < 4000; k++) begin
            for (int i = 0; i < N; i++) begin
                if (m_own[i]) begin
                    if ($urandom_range(5) == 0) r[i] = 1'b0;
                end else if (!r[i]) begin
                    if ($urandom_range(3) == 0) r[i] = 1'b1;
                end
            end
            cycle(r);
        end
        // Mid-run reset.
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R4 reset count", int'(poll_cnt), 0);
        check("R4 reset busy", int'(dev_busy), 0);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", vectors, 0);
        finish_run();
    end

endmodule